// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns a stream of oscillator-cycle enables (nominally 32,768 per second) into a one-cycle pulse once per second. It also applies a periodic digital trim. The trim runs over a repeating 64-minute cycle. In some of those minutes, the first second is made a little shorter or a little longer than nominal. The calibration magnitude sets how many minutes are trimmed, and the sign bit sets the direction. The correction acts at the divide-by-256 stage of the divider. A short second drops one whole stage period. A long second adds half of one stage period. So a positive step and a negative step are not the same size.

The surrounding timekeeper feeds the block a pulse at each minute rollover. The block uses that pulse to keep its own position within the 64-minute cycle. A stop input freezes the divider. A restart input realigns the divider phase. Both the crystal and the BCD time counters sit outside this block. The divider widths are parameters. The defaults give 256 enables per stage and 128 stages per second.

Top module: `cal_sec_prescaler`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `sec_tick` is 0. The minute index starts at 0. With a magnitude of 0, the first tick arrives after exactly NOM = 2^(PRE_W+HI_W) enables.
- R2: When no trim applies, every second lasts exactly NOM enabled cycles, and the tick comes one clock after the last enable.
- R3: Only cycles with `osc_en`=1 (and `stop`=0) advance the divider. Gaps in the enable stream lengthen the second in clock cycles, but never change its length in enables.
- R4: With `cal_pos`=1, the first second of a trimmed minute lasts NOM - 2^PRE_W enables.
- R5: With `cal_pos`=0, the first second of a trimmed minute lasts NOM + 2^(PRE_W-1) enables. No second ever exceeds that length.
- R6: A minute is trimmed only if its index within the cycle is below 2*`cal_mag`. Only the first second after the minute pulse is trimmed. Index 62 and index 63 are never trimmed.
- R7: A `cal_mag` of 0 applies no correction in any minute.
- R8: Each `minute_roll` pulse advances the 6-bit minute index by one. The index wraps from 63 to 0, so index 0 is trimmed again on the next cycle.
- R9: While `stop`=1, the divider holds its phase and `sec_tick` stays 0. After `stop` clears, counting resumes from the held phase.
- R10: A `restart` pulse clears the divider phase and cancels any pending trim. No tick follows it in the next cycle. The next tick comes after exactly NOM further enables.
- R11: `sec_tick` is high for exactly one clock cycle per second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| stop | input | 1 | Freezes the divider while high |
| restart | input | 1 | Clears the divider phase |
| cal_mag | input | MAG_W | Calibration magnitude (0 to 31) |
| cal_pos | input | 1 | Trim sign: 1 shortens the second (clock faster), 0 lengthens it |
| minute_roll | input | 1 | One-cycle pulse at each minute rollover |
| sec_tick | output | 1 | One-cycle pulse per second |

## Verification
The bench targets the edges of the trim window. It checks the last trimmed minute against the first untrimmed one, and index 61 against indices 62 and 63 at full magnitude. An off-by-one in the window compare would trim one minute too many or too few. The bench also confirms that the second after a trimmed one is nominal again. A design that failed to clear the pending flag would trim every second of the minute. The wrap from 63 to 0 is checked by the short second that should reappear at index 0. A stop held mid-second and a restart mid-second are both checked against exact enable counts. This exposes a divider that keeps counting while frozen, or one that keeps a stale trim after restart.

// File: rtl/cal_sec_pkg.sv
package cal_sec_pkg;

    localparam int MIN_W = 6;

    typedef enum logic [1:0] {
        TRIM_NONE  = 2'd0,
        TRIM_SHORT = 2'd1,
        TRIM_LONG  = 2'd2
    } trim_e;

    typedef struct packed {
        logic [MIN_W-1:0] idx;
        logic             fresh;
    } min_state_t;

    // Length of one second, counted in oscillator enables, for a trim mode.
    function automatic int unsigned sec_len(trim_e mode, int unsigned pre_w, int unsigned hi_w);
        int unsigned nom;
        nom = 32'd1 << (pre_w + hi_w);
        case (mode)
            TRIM_SHORT: return nom - (32'd1 << pre_w);
            TRIM_LONG:  return nom + (32'd1 << (pre_w - 1));
            default:    return nom;
        endcase
    endfunction

endpackage

// File: rtl/cal_sec_minute_track.sv
module cal_sec_minute_track
    import cal_sec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       minute_roll,
    input  logic       restart,
    input  logic       sec_tick,
    output min_state_t st
);

    // The pending-trim flag is armed at each minute start and dropped once a
    // second has been delivered (or the phase is restarted).
    always_ff @(posedge clk) begin
        if (rst) begin
            st.idx   <= '0;
            st.fresh <= 1'b1;
        end else if (minute_roll) begin
            st.idx   <= st.idx + 1'b1;
            st.fresh <= 1'b1;
        end else if (restart || sec_tick) begin
            st.fresh <= 1'b0;
        end
    end

endmodule

// File: rtl/cal_sec_trim_select.sv
module cal_sec_trim_select
    import cal_sec_pkg::*;
#(
    parameter int MAG_W = 5
) (
    input  min_state_t       st,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    output trim_e            mode
);

    logic [MAG_W:0] span;
    logic           in_window;

    assign span      = {cal_mag, 1'b0};
    assign in_window = (int'(st.idx) < int'(span));

    always_comb begin
        mode = TRIM_NONE;
        if (st.fresh && in_window) begin
            mode = cal_pos ? TRIM_SHORT : TRIM_LONG;
        end
    end

endmodule

// File: rtl/cal_sec_divider.sv
module cal_sec_divider
    import cal_sec_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int HI_W  = 7
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  osc_en,
    input  logic  stop,
    input  logic  restart,
    input  trim_e mode,
    output logic  sec_tick
);

    localparam int CW = PRE_W + HI_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last = CW'(sec_len(mode, PRE_W, HI_W) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
        end else if (osc_en && !stop) begin
            if (cnt >= last) begin
                cnt      <= '0;
                sec_tick <= 1'b1;
            end else begin
                cnt      <= cnt + 1'b1;
                sec_tick <= 1'b0;
            end
        end else begin
            sec_tick <= 1'b0;
        end
    end

endmodule

// File: rtl/cal_sec_prescaler.sv
module cal_sec_prescaler
    import cal_sec_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int HI_W  = 7,
    parameter int MAG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic             stop,
    input  logic             restart,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             minute_roll,
    output logic             sec_tick
);

    min_state_t       st;
    trim_e            mode;
    logic [MIN_W-1:0] min_idx;

    assign min_idx = st.idx;

    cal_sec_minute_track u_track (
        .clk         (clk),
        .rst         (rst),
        .minute_roll (minute_roll),
        .restart     (restart),
        .sec_tick    (sec_tick),
        .st          (st)
    );

    cal_sec_trim_select #(.MAG_W(MAG_W)) u_sel (
        .st      (st),
        .cal_mag (cal_mag),
        .cal_pos (cal_pos),
        .mode    (mode)
    );

    cal_sec_divider #(.PRE_W(PRE_W), .HI_W(HI_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .osc_en   (osc_en),
        .stop     (stop),
        .restart  (restart),
        .mode     (mode),
        .sec_tick (sec_tick)
    );

endmodule

// File: rtl/cal_sec_prescaler_chk.sv
module cal_sec_prescaler_chk
    import cal_sec_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int HI_W  = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             osc_en,
    input logic             stop,
    input logic             restart,
    input logic             minute_roll,
    input logic             sec_tick,
    input logic [MIN_W-1:0] min_idx
);

    localparam int unsigned LONG_LEN = (32'd1 << (PRE_W + HI_W)) + (32'd1 << (PRE_W - 1));

    // Counts enables seen since the last tick or restart.
    int unsigned en_seen;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            en_seen <= 0;
        end else if (sec_tick) begin
            en_seen <= (osc_en && !stop) ? 32'd1 : 32'd0;
        end else if (osc_en && !stop) begin
            en_seen <= en_seen + 1;
        end
    end

    assert_stop_hold_R9: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sec_tick);

    assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> !sec_tick);

    assert_minute_step_R8: assert property (@(posedge clk) disable iff (rst)
        minute_roll |=> (min_idx == MIN_W'($past(min_idx) + 1'b1)));

    assert_len_bound_R5: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (en_seen >= 1 && en_seen <= LONG_LEN));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

endmodule

bind cal_sec_prescaler cal_sec_prescaler_chk #(.PRE_W(PRE_W), .HI_W(HI_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_en      (osc_en),
    .stop        (stop),
    .restart     (restart),
    .minute_roll (minute_roll),
    .sec_tick    (sec_tick),
    .min_idx     (min_idx)
);

// File: tb/cal_sec_prescaler_bench.sv
module cal_sec_prescaler_bench;

    localparam int PRE_W = 4;
    localparam int HI_W  = 3;
    localparam int MAG_W = 5;
    localparam int NOM   = 1 << (PRE_W + HI_W);
    localparam int SHORT = NOM - (1 << PRE_W);
    localparam int LONG  = NOM + (1 << (PRE_W - 1));

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             osc_en = 1'b0;
    logic             stop = 1'b0;
    logic             restart = 1'b0;
    logic [MAG_W-1:0] cal_mag = '0;
    logic             cal_pos = 1'b0;
    logic             minute_roll = 1'b0;
    logic             sec_tick;

    int errors = 0;
    int checks = 0;
    int dens   = 100;
    int m_idx  = 0;
    bit m_fresh = 1'b1;
    int seed_val;

    always #5 clk = ~clk;

    cal_sec_prescaler #(.PRE_W(PRE_W), .HI_W(HI_W), .MAG_W(MAG_W)) u_cal_sec_prescaler (
        .clk         (clk),
        .rst         (rst),
        .osc_en      (osc_en),
        .stop        (stop),
        .restart     (restart),
        .cal_mag     (cal_mag),
        .cal_pos     (cal_pos),
        .minute_roll (minute_roll),
        .sec_tick    (sec_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_len();
        if (m_fresh && cal_mag != 0 && m_idx < 2 * int'(cal_mag))
            return cal_pos ? SHORT : LONG;
        return NOM;
    endfunction

    task automatic roll();
        minute_roll = 1'b1;
        @(negedge clk);
        minute_roll = 1'b0;
        m_idx   = (m_idx + 1) % 64;
        m_fresh = 1'b1;
    endtask

    // Counts enables until a tick, optionally stopping or restarting mid-second.
    task automatic measure(input int stop_at, input int restart_at, input string req);
        int cnt = 0;
        int guard = 0;
        int exp;
        bit seen = 1'b0;
        bit stray = 1'b0;
        exp = model_len();
        while (!seen && guard < 4000) begin
            @(negedge clk);
            guard++;
            restart = 1'b0;
            if (sec_tick) begin
                seen = 1'b1;
                osc_en = 1'b0;
            end else if (stop_at >= 0 && cnt == stop_at) begin
                stop_at = -1;
                stop = 1'b1;
                osc_en = 1'b1;
                repeat (40) begin
                    @(negedge clk);
                    if (sec_tick) stray = 1'b1;
                end
                stop = 1'b0;
                osc_en = 1'b0;
                check(!stray, "R9 no tick while stopped", int'(stray), 0);
            end else if (restart_at >= 0 && cnt == restart_at) begin
                restart_at = -1;
                restart = 1'b1;
                osc_en = 1'b1;
                cnt = 0;
                m_fresh = 1'b0;
                exp = NOM;
            end else begin
                osc_en = (int'($urandom % 100) < dens) ? 1'b1 : 1'b0;
                cnt += int'(osc_en);
            end
        end
        m_fresh = 1'b0;
        check(seen && cnt == exp, req, cnt, exp);
        @(negedge clk);
        check(!sec_tick, "R11 tick width one cycle", int'(sec_tick), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(sec_tick == 1'b0, "R1 tick low in reset", int'(sec_tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sec_tick == 1'b0, "R1 tick low after reset", int'(sec_tick), 0);

        // Magnitude 0: nominal seconds, including the first minute.
        measure(-1, -1, "R1 R7 first second with zero magnitude");
        measure(-1, -1, "R2 nominal second");
        roll();
        measure(-1, -1, "R7 zero magnitude leaves minute untrimmed");

        // Positive trim on minute 2 of window 0..5
        cal_mag = 5'd3;
        cal_pos = 1'b1;
        roll();
        measure(-1, -1, "R4 short first second");
        measure(-1, -1, "R6 second second nominal");
        cal_pos = 1'b0;
        roll();
        measure(-1, -1, "R5 long first second");
        roll();
        roll();
        measure(-1, -1, "R6 last trimmed minute");
        roll();
        measure(-1, -1, "R6 first untrimmed minute");

        // Enable gaps
        dens = 40;
        measure(-1, -1, "R3 sparse enables");
        dens = 100;

        // Stop mid-second, then restart mid-second
        roll();
        measure(50, -1, "R9 stop holds phase");
        cal_mag = 5'd31;
        cal_pos = 1'b1;
        while (m_idx != 3) roll();
        measure(-1, 37, "R10 restart cancels trim and realigns");

        // Constrained random
        for (int i = 0; i < 40; i++) begin
            int nr;
            cal_mag = MAG_W'($urandom % 32);
            cal_pos = 1'($urandom % 2);
            dens    = 50 + int'($urandom % 51);
            nr      = int'($urandom % 3);
            for (int k = 0; k < nr; k++) roll();
            measure(-1, -1, "R2 R4 R5 R6 random second");
        end
        dens = 100;

        // Upper window edge and wrap
        cal_mag = 5'd31;
        cal_pos = 1'b1;
        while (m_idx != 61) roll();
        measure(-1, -1, "R6 index 61 trimmed at full magnitude");
        roll();
        measure(-1, -1, "R6 index 62 never trimmed");
        roll();
        measure(-1, -1, "R6 index 63 never trimmed");
        roll();
        measure(-1, -1, "R8 wrap to index 0 trimmed again");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule